// File: doc/BRIEF.md
# Quad DAC Serial Command Front End

This block is the digital side of a four-channel, 8-bit digital-to-analog converter. A host shifts a 12-bit command into it over a three-wire SPI-style link: an active-low select, a serial clock and a data line. When the select line returns high, the block decodes the word. The decoded word gives a channel address, eight data bits and two active-low shutdown controls. The data goes into the addressed channel's input register. The shutdown controls set or clear per-channel shutdown flags.

Each channel has an input register followed by an output (DAC) register. An active-low load strobe is level sensitive. While it is low, every output register follows its input register, so all channels change together. While it is high, the output registers hold their values. A shut-down channel drives a zero code on its output but keeps accepting new data. An asynchronous active-low clear zeros every input and output register. A power-on reset zeros everything.

All serial pins and the strobe are oversampled in the system clock domain through synchronizers. For this reason the serial clock must run well below the system clock.

Top module: `quad_dac_frontend`

## Requirements
- R1: After reset every channel code output is 0 and every shutdown flag is 0.
- R2: A command is 12 bits, sent MSB first, with the data line sampled on rising serial-clock edges while the select is low. The layout from bit 11 down is: address[1:0], all-channel shutdown (bit 9, active 0), addressed-channel shutdown (bit 8, active 0), data[7:0].
- R3: When the select rises, only the last 12 bits shifted in are decoded. A 16-bit frame whose last 12 bits form a command acts as that command.
- R4: The 8 data bits are written only into the input register of the channel given by the address bits (0 to 3). Other channels keep their values.
- R5: With bit 9 = 1 and bit 8 = 0, the addressed channel's shutdown flag is set. With both bits = 1, only that channel's flag is cleared.
- R6: With bit 9 = 0, all four shutdown flags are set, whatever bit 8 holds.
- R7: A channel whose flag is set outputs code 0. Its registers still take new data, and that data shows on the output once the flag clears.
- R8: While the load strobe is high, the output registers hold their values. While it is low, all output registers follow their input registers.
- R9: A low level on the clear input zeros all input and output registers. The shutdown flags are not changed.
- R10: The shift register is zeroed at each select fall. A frame of fewer than 12 bits therefore decodes with zeros in the unsent upper bits.
- R11: Serial clock edges while the select is high change no register or output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all serial pins are oversampled on its rising edge |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| cs_n | input | 1 | Serial select, active low; its rising edge commits the command |
| sclk | input | 1 | Serial bit clock |
| sdi | input | 1 | Serial data, MSB first |
| ldac_n | input | 1 | Level-sensitive load strobe, active low |
| clr_n | input | 1 | Asynchronous clear of input and output registers, active low |
| dac_code_o | output | 32 | Four 8-bit channel codes, channel 0 in bits 7:0 |
| shdn_o | output | 4 | Per-channel shutdown flags, bit n for channel n |

## Verification
A committed command reaches the outputs a fixed number of system cycles after the select rises. The path is two synchronizer stages, one edge-detect register, the input register write and the output register copy, which comes to about five cycles. A change of the load strobe reaches the outputs through the same synchronizer and the output register copy. The clear acts at once, with no clock needed. The scoreboard monitor waits ten cycles after each expectation is queued, which covers every one of these paths. It then samples between clock edges. The driver does not start the next stimulus until that expectation has been compared, so no result can be checked against the wrong command.

// File: rtl/qdac_pkg.sv
package qdac_pkg;

   // Outcome of decoding the two active-low shutdown bits of a command
   typedef enum logic [1:0] {
      SDA_WAKE_ONE = 2'd0,
      SDA_SLEEP_ONE = 2'd1,
      SDA_SLEEP_ALL = 2'd2
   } sd_action_e;

   function automatic sd_action_e sd_decode(input logic all_n, input logic one_n);
      if (!all_n)
         return SDA_SLEEP_ALL;
      else if (!one_n)
         return SDA_SLEEP_ONE;
      else
         return SDA_WAKE_ONE;
   endfunction

endpackage

// File: rtl/qdac_sync.sv
module qdac_sync #(
   parameter int WIDTH = 1,
   parameter int STAGES = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (STAGES < 0) begin : g_bad_stages
      $error("qdac_sync: STAGES must not be negative");
   end

   if (STAGES == 0) begin : g_bypass
      assign q = d;
   end else begin : g_chain
      logic [WIDTH-1:0] st [STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) st[i] <= RST_VAL;
         end else begin
            st[0] <= d;
            for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
         end
      end
      assign q = st[STAGES-1];
   end

endmodule

// File: rtl/qdac_shifter.sv
module qdac_shifter #(
   parameter int WORD_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_s,
   input  logic              sclk_s,
   input  logic              sdi_s,
   output logic              commit,
   output logic [WORD_W-1:0] word
);

   logic              cs_q;
   logic              sclk_q;
   logic [WORD_W-1:0] shreg;
   logic              bit_stb;
   logic              frame_start;

   assign bit_stb     = sclk_s & ~sclk_q & ~cs_s;
   assign frame_start = ~cs_s & cs_q;
   assign commit      = cs_s & ~cs_q;
   assign word        = shreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_q   <= 1'b1;
         sclk_q <= 1'b0;
         shreg  <= '0;
      end else begin
         cs_q   <= cs_s;
         sclk_q <= sclk_s;
         if (frame_start)
            shreg <= '0;
         else if (bit_stb)
            shreg <= {shreg[WORD_W-2:0], sdi_s};
      end
   end

endmodule

// File: rtl/qdac_regbank.sv
module qdac_regbank
   import qdac_pkg::*;
#(
   parameter int NUM_CH = 4,
   parameter int DATA_W = 8,
   localparam int ADDR_W = $clog2(NUM_CH)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     clr_n,
   input  logic                     commit,
   input  logic [ADDR_W-1:0]        addr,
   input  logic                     all_sd_n,
   input  logic                     one_sd_n,
   input  logic [DATA_W-1:0]        data,
   input  logic                     ldac_s,
   output logic [NUM_CH*DATA_W-1:0] in_q,
   output logic [NUM_CH*DATA_W-1:0] dac_q,
   output logic [NUM_CH-1:0]        sd_q
);

   logic       data_rst_n;
   sd_action_e act;

   assign data_rst_n = rst_n & clr_n;
   assign act        = sd_decode(all_sd_n, one_sd_n);

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      logic sel;
      assign sel = (addr == ADDR_W'(i));

      always_ff @(posedge clk or negedge data_rst_n) begin
         if (!data_rst_n)
            in_q[i*DATA_W +: DATA_W] <= '0;
         else if (commit && sel)
            in_q[i*DATA_W +: DATA_W] <= data;
      end

      always_ff @(posedge clk or negedge data_rst_n) begin
         if (!data_rst_n)
            dac_q[i*DATA_W +: DATA_W] <= '0;
         else if (!ldac_s)
            dac_q[i*DATA_W +: DATA_W] <= in_q[i*DATA_W +: DATA_W];
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            sd_q[i] <= 1'b0;
         else if (commit) begin
            unique case (act)
               SDA_SLEEP_ALL: sd_q[i] <= 1'b1;
               SDA_SLEEP_ONE: if (sel) sd_q[i] <= 1'b1;
               default:       if (sel) sd_q[i] <= 1'b0;
            endcase
         end
      end
   end

endmodule

// File: rtl/quad_dac_frontend.sv
module quad_dac_frontend #(
   parameter int NUM_CH = 4,
   parameter int DATA_W = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cs_n,
   input  logic                     sclk,
   input  logic                     sdi,
   input  logic                     ldac_n,
   input  logic                     clr_n,
   output logic [NUM_CH*DATA_W-1:0] dac_code_o,
   output logic [NUM_CH-1:0]        shdn_o
);

   localparam int ADDR_W = $clog2(NUM_CH);
   localparam int WORD_W = ADDR_W + 2 + DATA_W;
   localparam int BIT_ALL = DATA_W + 1;
   localparam int BIT_ONE = DATA_W;

   if (NUM_CH < 2 || (1 << ADDR_W) != NUM_CH) begin : g_bad_ch
      $error("quad_dac_frontend: NUM_CH must be a power of two, at least 2");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("quad_dac_frontend: DATA_W must be positive");
   end

   logic [3:0]               raw_in;
   logic [3:0]               syn;
   logic                     ldac_s, cs_s, sclk_s, sdi_s;
   logic                     commit;
   logic [WORD_W-1:0]        cmd_word;
   logic [NUM_CH*DATA_W-1:0] in_q;
   logic [NUM_CH*DATA_W-1:0] dac_q;

   assign raw_in = {ldac_n, cs_n, sclk, sdi};

   qdac_sync #(
      .WIDTH   (4),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (4'b1100)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw_in),
      .q     (syn)
   );

   assign {ldac_s, cs_s, sclk_s, sdi_s} = syn;

   qdac_shifter #(
      .WORD_W (WORD_W)
   ) u_shift (
      .clk    (clk),
      .rst_n  (rst_n),
      .cs_s   (cs_s),
      .sclk_s (sclk_s),
      .sdi_s  (sdi_s),
      .commit (commit),
      .word   (cmd_word)
   );

   qdac_regbank #(
      .NUM_CH (NUM_CH),
      .DATA_W (DATA_W)
   ) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_n    (clr_n),
      .commit   (commit),
      .addr     (cmd_word[WORD_W-1 -: ADDR_W]),
      .all_sd_n (cmd_word[BIT_ALL]),
      .one_sd_n (cmd_word[BIT_ONE]),
      .data     (cmd_word[DATA_W-1:0]),
      .ldac_s   (ldac_s),
      .in_q     (in_q),
      .dac_q    (dac_q),
      .sd_q     (shdn_o)
   );

   for (genvar i = 0; i < NUM_CH; i++) begin : g_out
      assign dac_code_o[i*DATA_W +: DATA_W] =
         shdn_o[i] ? '0 : dac_q[i*DATA_W +: DATA_W];
   end

endmodule

// File: rtl/qdac_chk.sv
module qdac_chk #(
   parameter int NUM_CH = 4,
   parameter int DATA_W = 8,
   localparam int ADDR_W = $clog2(NUM_CH),
   localparam int WORD_W = ADDR_W + 2 + DATA_W
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     clr_n,
   input logic                     commit,
   input logic [WORD_W-1:0]        word,
   input logic                     ldac_s,
   input logic [NUM_CH*DATA_W-1:0] in_q,
   input logic [NUM_CH*DATA_W-1:0] dac_q,
   input logic [NUM_CH-1:0]        shdn,
   input logic [NUM_CH*DATA_W-1:0] code
);

   AST_ALL_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && !word[DATA_W+1]) |=> (&shdn)); // R6

   AST_ONE_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && word[DATA_W+1] && !word[DATA_W]) |=>
      ((shdn >> $past(word[WORD_W-1 -: ADDR_W])) & 1) != 0); // R5

   AST_ONE_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && word[DATA_W+1] && word[DATA_W]) |=>
      ((shdn >> $past(word[WORD_W-1 -: ADDR_W])) & 1) == 0); // R5

   AST_FLAGS_ONLY_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> $stable(shdn)); // R11

   AST_FOLLOW_WHEN_LOW: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
      (!ldac_s && clr_n) |=> (dac_q == $past(in_q))); // R8

   AST_HOLD_WHEN_HIGH: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
      ($past(clr_n) && !$stable(dac_q)) |-> !$past(ldac_s)); // R8

   AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_n |-> (code == '0 && in_q == '0)); // R9

endmodule

bind quad_dac_frontend qdac_chk #(
   .NUM_CH (NUM_CH),
   .DATA_W (DATA_W)
) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .clr_n  (clr_n),
   .commit (commit),
   .word   (cmd_word),
   .ldac_s (ldac_s),
   .in_q   (in_q),
   .dac_q  (dac_q),
   .shdn   (shdn_o),
   .code   (dac_code_o)
);

// File: tb/sim_quad_dac_frontend.sv
module sim_quad_dac_frontend;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs_n = 1'b1;
   logic        sclk = 1'b0;
   logic        sdi = 1'b0;
   logic        ldac_n = 1'b1;
   logic        clr_n = 1'b1;
   logic [31:0] dac_code_o;
   logic [3:0]  shdn_o;

   int n_checks = 0;
   int n_fails = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   quad_dac_frontend u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .cs_n       (cs_n),
      .sclk       (sclk),
      .sdi        (sdi),
      .ldac_n     (ldac_n),
      .clr_n      (clr_n),
      .dac_code_o (dac_code_o),
      .shdn_o     (shdn_o)
   );

   typedef struct {
      string      req;
      logic [31:0] code;
      logic [3:0]  sd;
   } exp_t;

   exp_t q[$];

   // Reference model built from the requirements
   logic [7:0] in_m  [4];
   logic [7:0] dac_m [4];
   logic [3:0] sd_m;
   logic       ldac_lv;

   task automatic push_exp(input string req);
      exp_t e;
      e.req = req;
      e.sd  = sd_m;
      for (int i = 0; i < 4; i++)
         e.code[i*8 +: 8] = sd_m[i] ? 8'h00 : dac_m[i];
      q.push_back(e);
      wait (q.size() == 0);
   endtask

   task automatic follow();
      if (!ldac_lv)
         for (int i = 0; i < 4; i++) dac_m[i] = in_m[i];
   endtask

   task automatic shift_bit(input logic b);
      @(posedge clk); #2;
      sdi = b;
      repeat (4) @(posedge clk); #2;
      sclk = 1'b1;
      repeat (4) @(posedge clk); #2;
      sclk = 1'b0;
   endtask

   task automatic send_frame(input logic [31:0] v, input int nbits);
      @(posedge clk); #2;
      cs_n = 1'b0;
      repeat (4) @(posedge clk);
      for (int i = nbits - 1; i >= 0; i--) shift_bit(v[i]);
      repeat (4) @(posedge clk); #2;
      cs_n = 1'b1;
   endtask

   task automatic model_cmd(input logic [11:0] w);
      int a;
      a = int'(w[11:10]);
      in_m[a] = w[7:0];
      if (!w[9]) sd_m = 4'hF;
      else if (!w[8]) sd_m[a] = 1'b1;
      else sd_m[a] = 1'b0;
      follow();
   endtask

   task automatic cmd(input logic [11:0] w, input string req);
      model_cmd(w);
      send_frame({20'h0, w}, 12);
      push_exp(req);
   endtask

   task automatic set_ldac(input logic v, input string req);
      @(posedge clk); #2;
      ldac_n = v;
      ldac_lv = v;
      follow();
      push_exp(req);
   endtask

   // Monitor: pops each expectation once its results are due
   initial begin
      forever begin
         wait (q.size() > 0);
         repeat (10) @(posedge clk);
         #3;
         for (int i = 0; i < 4; i++) begin
            n_checks++;
            if (dac_code_o[i*8 +: 8] !== q[0].code[i*8 +: 8] ||
                shdn_o[i] !== q[0].sd[i]) begin
               n_fails++;
               $display("FAIL %s ch%0d: code=%h sd=%b expected code=%h sd=%b",
                        q[0].req, i, dac_code_o[i*8 +: 8], shdn_o[i],
                        q[0].code[i*8 +: 8], q[0].sd[i]);
            end
         end
         void'(q.pop_front());
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_fails++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 4; i++) begin
         in_m[i] = 8'h00;
         dac_m[i] = 8'h00;
      end
      sd_m = 4'h0;
      ldac_lv = 1'b1;
      repeat (3) @(posedge clk); #2;
      rst_n = 1'b1;
      push_exp("R1");

      // transparent mode, plain write to channel 2 (R2, R4)
      set_ldac(1'b0, "R8");
      cmd({2'd2, 1'b1, 1'b1, 8'h5A}, "R2 R4");

      // 16-bit frame: leading nibble is discarded (R3)
      model_cmd({2'd1, 1'b1, 1'b1, 8'h3C});
      send_frame({16'h0, 4'hF, 2'd1, 1'b1, 1'b1, 8'h3C}, 16);
      push_exp("R3");

      // serial clocks with select high are ignored (R11)
      for (int i = 0; i < 14; i++) shift_bit(i[0]);
      push_exp("R11");

      // hold with strobe high, then release (R8)
      set_ldac(1'b1, "R8");
      cmd({2'd0, 1'b1, 1'b1, 8'h77}, "R8 hold");
      set_ldac(1'b0, "R8 follow");

      // addressed-channel shutdown and wake (R5, R7)
      cmd({2'd3, 1'b1, 1'b0, 8'h99}, "R5 R7 sleep");
      cmd({2'd3, 1'b1, 1'b1, 8'h44}, "R5 R7 wake");

      // all-channel shutdown with bit 8 inactive and active (R6)
      cmd({2'd0, 1'b0, 1'b1, 8'h10}, "R6");
      cmd({2'd1, 1'b1, 1'b1, 8'h21}, "R5 R7");
      cmd({2'd2, 1'b0, 1'b0, 8'h32}, "R6 R7");
      for (int a = 0; a < 4; a++)
         cmd({a[1:0], 1'b1, 1'b1, 8'hA0 + 8'(a)}, "R7 wake");

      // short 8-bit frame: upper bits zero, so all channels sleep (R10)
      model_cmd({4'h0, 8'hAB});
      send_frame({24'h0, 8'hAB}, 8);
      push_exp("R10");
      cmd({2'd0, 1'b1, 1'b1, 8'hAB}, "R10 R7");

      // asynchronous clear keeps flags (R9)
      cmd({2'd1, 1'b1, 1'b0, 8'h55}, "R5");
      @(posedge clk); #2;
      clr_n = 1'b0;
      for (int i = 0; i < 4; i++) begin
         in_m[i] = 8'h00;
         dac_m[i] = 8'h00;
      end
      push_exp("R9");
      @(posedge clk); #2;
      clr_n = 1'b1;
      cmd({2'd2, 1'b1, 1'b1, 8'hC3}, "R9 R4");

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

endmodule